// File: doc/BRIEF.md
# Two-Wire EEPROM Byte-Write Slave

This block is the bus-facing half of a small serial EEPROM that supports only the single-byte write transaction. It oversamples the two-wire clock and data lines with the system clock and recognises bus Start and Stop conditions. After a Start it takes three bytes in turn. The first is the device select byte, which must carry the fixed family code, the strapped chip address and a write direction bit. The second is the memory location. The third is the value to store. The slave pulls the data line low to acknowledge each byte it accepts.

The write is committed only when the master closes the transfer with a Stop. At that point the block issues a single-cycle write strobe that carries location and value to the memory array, and it holds a busy flag for a fixed number of system clocks. During that time the block ignores the bus completely. When the period ends, a one-cycle ready pulse announces that the array can take a new transaction. Stray Starts or Stops in the middle of a transfer discard it without writing anything.

Top module: `eeprom_bytewr_slave`

## Requirements
- R1: After reset `sda_oe_o`, `wr_stb_o`, `busy_o` and `ready_o` are all low.
- R2: The first byte after a Start is taken MSB first on rising SCL. It is acknowledged when its bits [7:4] equal 4'b1010, its bits [3:1] equal `strap_addr_i`, and bit [0] (the direction bit) is 0. An acknowledge means `sda_oe_o` is high while SCL is high during the ninth clock.
- R3: A select byte that fails any of the R2 tests gets no acknowledge. The slave then acknowledges nothing and writes nothing until the next Start.
- R4: The second byte is acknowledged and becomes `wr_addr_o` of the resulting write strobe. `wr_addr_o` holds steady while busy.
- R5: The third byte is acknowledged and becomes `wr_data_o` of the resulting write strobe.
- R6: A write is committed only by a Stop that follows the third byte's acknowledge. Before that Stop there is no strobe. Each committed write gives exactly one `wr_stb_o` pulse, one cycle long.
- R7: A Stop or Start that arrives before the third byte's acknowledge clock has finished aborts the transfer without a write. A repeated Start begins select-byte matching again.
- R8: `busy_o` rises in the same cycle as `wr_stb_o` and stays high for exactly WRITE_CYCLES system clocks.
- R9: While `busy_o` is high, no bus activity produces an acknowledge or a write strobe.
- R10: `ready_o` pulses high for one cycle, in the first cycle after `busy_o` falls.
- R11: The acknowledge drive is released after the falling edge of the ninth SCL clock, before the next bit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Two-wire bus clock, asynchronous |
| sda_i | input | 1 | Two-wire bus data as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | High pulls the open-drain data line low (acknowledge) |
| strap_addr_i | input | 3 | Strapped chip address compared with select bits [3:1] |
| wr_stb_o | output | 1 | One-cycle memory write strobe |
| wr_addr_o | output | 8 | Memory location for the write |
| wr_data_o | output | 8 | Value to write |
| busy_o | output | 1 | Internal write cycle in progress |
| ready_o | output | 1 | One-cycle pulse when the write cycle ends |

## Verification
The bench builds the slave with WRITE_CYCLES set to 400 in place of the default 5000. The busy window is then short enough that dozens of complete transactions fit in the run. It is still longer than a Start plus a full select byte (about 170 clocks at the bench bus rate), so the bench can address the slave in the middle of its write cycle and see it stay silent. SYNC_STAGES keeps its default of two, and the bench bus half-period of eight clocks leaves margin over the synchroniser delay for the acknowledge and release samples.

// File: rtl/eewr_pkg.sv
// Shared constants and types for the two-wire byte-write slave.
// Assumes an 8-bit byte and a select byte split into family code,
// strap address and direction bit.
package eewr_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int ID_W    = BYTE_W - STRAP_W - 1;
    localparam logic [ID_W-1:0] FAMILY_CODE = 4'b1010;

    // Bit counter values: 8 = byte received, 9 = ack clock high seen
    localparam logic [3:0] BITS_FULL = 4'd8;
    localparam logic [3:0] BITS_ACK  = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for Start
        PH_SEL,    // receiving select byte
        PH_LOC,    // receiving memory location
        PH_VAL,    // receiving data value
        PH_ARMED   // all bytes acked, waiting for Stop
    } eewr_phase_e;
endpackage

// File: rtl/eewr_line_sync.sv
// Line synchroniser and bus event detector.
// Brings SCL and SDA into the clock domain through SYNC_STAGES flops
// (reset to the idle-high bus level). It then flags SCL edges and
// Start/Stop conditions from consecutive synchronised samples.
// Assumes the bus is slow compared with clk (several clocks per phase).
module eewr_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_chain;
    logic [MSB:0] sda_chain;
    logic         scl_prev;
    logic         sda_prev;
    logic         scl_now;
    logic         sda_now;

    // Shift raw lines through the synchroniser chains and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[MSB-1:0], scl_i};
            sda_chain <= {sda_chain[MSB-1:0], sda_i};
            scl_prev  <= scl_chain[MSB];
            sda_prev  <= sda_chain[MSB];
        end
    end

    // Decode bus events from the newest and previous synchronised samples
    always_comb begin
        scl_now    = scl_chain[MSB];
        sda_now    = sda_chain[MSB];
        sda_o      = sda_now;
        scl_rise_o = scl_now & ~scl_prev;
        scl_fall_o = ~scl_now & scl_prev;
        start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/eewr_byte_engine.sv
// Transaction engine for the byte-write sequence.
// Shifts bits in MSB first on SCL rise. It decides acceptance after the
// eighth bit, drives the acknowledge through the ninth clock and releases
// it on that clock's falling edge. It raises a one-cycle commit when a Stop
// follows an acknowledged data byte.
// Assumes hold_i is high for the whole internal write cycle; the engine
// then stays idle and silent.
module eewr_byte_engine
    import eewr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_i,
    input  logic               sda_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               ack_drive_o,
    output logic               commit_o,
    output logic [BYTE_W-1:0]  loc_o,
    output logic [BYTE_W-1:0]  val_o
);
    eewr_phase_e       phase;
    eewr_phase_e       phase_after;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_on;
    logic              sel_match;
    logic              byte_ok;
    logic              receiving;

    // Select byte test: family code, strap address and write direction
    always_comb begin
        sel_match = (shreg[BYTE_W-1 -: ID_W] == FAMILY_CODE)
                  && (shreg[STRAP_W:1] == strap_i)
                  && (shreg[0] == 1'b0);
        byte_ok   = (phase == PH_SEL) ? sel_match : 1'b1;
        receiving = (phase == PH_SEL) || (phase == PH_LOC) || (phase == PH_VAL);
    end

    // Phase that follows a completed acknowledge clock
    always_comb begin
        case (phase)
            PH_SEL:  phase_after = PH_LOC;
            PH_LOC:  phase_after = PH_VAL;
            PH_VAL:  phase_after = PH_ARMED;
            default: phase_after = PH_IDLE;
        endcase
    end

    // Sequence the transfer: events first, then bit and ack handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ack_on   <= 1'b0;
            commit_o <= 1'b0;
            loc_o    <= '0;
            val_o    <= '0;
        end else begin
            commit_o <= 1'b0;
            if (hold_i) begin
                phase   <= PH_IDLE;
                ack_on  <= 1'b0;
                bit_cnt <= '0;
            end else if (start_i) begin
                phase   <= PH_SEL;
                ack_on  <= 1'b0;
                bit_cnt <= '0;
            end else if (stop_i) begin
                commit_o <= (phase == PH_ARMED);
                phase    <= PH_IDLE;
                ack_on   <= 1'b0;
                bit_cnt  <= '0;
            end else if (receiving) begin
                if (scl_rise_i) begin
                    if (bit_cnt < BITS_FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (bit_cnt == BITS_FULL && ack_on) begin
                        bit_cnt <= BITS_ACK;
                    end
                end else if (scl_fall_i) begin
                    if (bit_cnt == BITS_FULL && !ack_on) begin
                        if (byte_ok) begin
                            ack_on <= 1'b1;
                            if (phase == PH_LOC) loc_o <= shreg;
                            if (phase == PH_VAL) val_o <= shreg;
                        end else begin
                            phase   <= PH_IDLE;
                            bit_cnt <= '0;
                        end
                    end else if (bit_cnt == BITS_ACK) begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        phase   <= phase_after;
                    end
                end
            end
        end
    end

    assign ack_drive_o = ack_on;
endmodule

// File: rtl/eewr_write_timer.sv
// Internal write-cycle timer.
// On commit it latches location and value, pulses the write strobe once,
// and keeps busy high for WRITE_CYCLES clocks. It then pulses ready.
// Assumes WRITE_CYCLES >= 1 and that commit does not arrive while busy.
module eewr_write_timer
    import eewr_pkg::*;
#(
    parameter int WRITE_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [BYTE_W-1:0] loc_i,
    input  logic [BYTE_W-1:0] val_i,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              ready_o
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Launch the write and count down the busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            busy_o    <= 1'b0;
            ready_o   <= 1'b0;
            remain    <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            ready_o  <= 1'b0;
            if (commit_i && !busy_o) begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= loc_i;
                wr_data_o <= val_i;
                busy_o    <= 1'b1;
                remain    <= LAST_TICK;
            end else if (busy_o) begin
                if (remain == '0) begin
                    busy_o  <= 1'b0;
                    ready_o <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_bytewr_slave.sv
// Top of the two-wire byte-write slave.
// Chains the line synchroniser, the transaction engine and the write timer.
// The engine is held idle from commit until the busy window ends, so the
// bus is ignored for the whole write cycle.
// Assumes sda_i is the wired line including this block's own pull-down.
module eeprom_bytewr_slave #(
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_addr_i,
    output logic       wr_stb_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       busy_o,
    output logic       ready_o
);
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       bus_start;
    logic       bus_stop;
    logic       commit;
    logic       hold;
    logic [7:0] loc;
    logic [7:0] val;

    // Keep the engine deaf from commit through the end of the busy window
    always_comb hold = busy_o | commit;

    eewr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    eewr_byte_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold),
        .sda_i       (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (bus_start),
        .stop_i      (bus_stop),
        .strap_i     (strap_addr_i),
        .ack_drive_o (sda_oe_o),
        .commit_o    (commit),
        .loc_o       (loc),
        .val_o       (val)
    );

    eewr_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .loc_i     (loc),
        .val_i     (val),
        .wr_stb_o  (wr_stb_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .busy_o    (busy_o),
        .ready_o   (ready_o)
    );
endmodule

// File: rtl/eewr_checks.sv
// Protocol checker for the byte-write slave, attached by bind.
// Relates strobe, busy, ready and acknowledge at the top-level ports.
module eewr_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe_o,
    input logic       wr_stb_o,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o,
    input logic       busy_o,
    input logic       ready_o
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb_o |=> !wr_stb_o); // R6
    AST_STB_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_stb_o |-> busy_o); // R8
    AST_BUSY_STARTS_AT_STB: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> wr_stb_o); // R8
    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> !sda_oe_o); // R9
    AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ready_o |-> (!busy_o && $past(busy_o))); // R10
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ready_o |=> !ready_o); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !wr_stb_o) |-> ($stable(wr_addr_o) && $stable(wr_data_o))); // R4
endmodule

bind eeprom_bytewr_slave eewr_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_o  (sda_oe_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .busy_o    (busy_o),
    .ready_o   (ready_o)
);

// File: tb/eeprom_bytewr_slave_tb.sv
module eeprom_bytewr_slave_tb;
    localparam int WCYC  = 400;
    localparam int HP    = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic wr_stb, busy, ready;
    logic [7:0] wr_addr, wr_data;

    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    int ready_cnt = 0;
    int busy_run = 0;
    int last_run = 0;
    logic [7:0] last_addr = '0;
    logic [7:0] last_data = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    eeprom_bytewr_slave #(.WRITE_CYCLES(WCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_addr_i(STRAP), .wr_stb_o(wr_stb),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy), .ready_o(ready)
    );

    // Output monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_cnt++;
                last_addr = wr_addr;
                last_data = wr_data;
            end
            if (ready) ready_cnt++;
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                last_run = busy_run;
                busy_run = 0;
            end
        end
    end

    function automatic bit sel_ok(input logic [7:0] b);
        return (b[7:4] == 4'b1010) && (b[3:1] == STRAP) && (b[0] == 1'b0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_n(HP/2);
        scl = 1'b1;   wait_n(HP);
        m_sda = 1'b0; wait_n(HP);
        scl = 1'b0;   wait_n(HP/2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_n(HP/2);
        scl = 1'b1;   wait_n(HP);
        m_sda = 1'b1; wait_n(HP);
    endtask

    // Sends one byte with SCL low on entry; returns the sampled acknowledge
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_n(HP/2);
            scl = 1'b1;   wait_n(HP);
            scl = 1'b0;   wait_n(HP/2);
        end
        m_sda = 1'b1; wait_n(HP/2);
        scl = 1'b1;   wait_n(HP/2);
        acked = sda_oe;
        wait_n(HP/2);
        scl = 1'b0;   wait_n(HP);
        if (acked) chk(sda_oe == 1'b0, "R11 ack released", int'(sda_oe), 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        wait_n(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a0, a1, a2;
        int s0, r0;
        void'($urandom(32'd20240611));
        wait_n(5);
        // R1: reset state
        chk(!sda_oe && !wr_stb && !busy && !ready, "R1 reset outputs",
            int'({sda_oe, wr_stb, busy, ready}), 0);
        rst_n = 1'b1;
        wait_n(5);

        // R2 R4 R5 R6 R8 R10: directed full write, strobe only on Stop
        s0 = stb_cnt; r0 = ready_cnt;
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a0);
        chk(a0, "R2 select ack", int'(a0), 1);
        send_byte(8'h3C, a1);
        chk(a1, "R4 location ack", int'(a1), 1);
        send_byte(8'hA5, a2);
        chk(a2, "R5 value ack", int'(a2), 1);
        wait_n(3 * HP);
        chk(stb_cnt == s0, "R6 no strobe before Stop", stb_cnt - s0, 0);
        bus_stop();
        wait_n(4);
        chk(stb_cnt == s0 + 1, "R6 one strobe on Stop", stb_cnt - s0, 1);
        chk(last_addr == 8'h3C, "R4 strobe location", int'(last_addr), 'h3C);
        chk(last_data == 8'hA5, "R5 strobe value", int'(last_data), 'hA5);
        chk(busy == 1'b1, "R8 busy after strobe", int'(busy), 1);

        // R9: addressed during the write cycle, slave stays silent
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a0);
        chk(!a0, "R9 no ack while busy", int'(a0), 0);
        chk(busy == 1'b1, "R9 still busy during probe", int'(busy), 1);
        bus_stop();
        wait_idle();
        chk(stb_cnt == s0 + 1, "R9 no strobe while busy", stb_cnt - s0, 1);
        chk(last_run == WCYC, "R8 busy length", last_run, WCYC);
        chk(ready_cnt == r0 + 1, "R10 ready pulse", ready_cnt - r0, 1);

        // R3: wrong family code, then following bytes ignored
        s0 = stb_cnt;
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, a0);
        send_byte(8'h11, a1);
        send_byte(8'h22, a2);
        bus_stop(); wait_n(8);
        chk(!a0 && !a1 && !a2, "R3 bad family code", int'({a0, a1, a2}), 0);
        chk(stb_cnt == s0, "R3 no write after mismatch", stb_cnt - s0, 0);

        // R3: read direction bit and wrong strap
        bus_start();
        send_byte({4'b1010, STRAP, 1'b1}, a0);
        bus_stop(); wait_n(8);
        chk(!a0, "R3 read direction refused", int'(a0), 0);
        bus_start();
        send_byte({4'b1010, ~STRAP, 1'b0}, a0);
        bus_stop(); wait_n(8);
        chk(!a0, "R3 wrong strap refused", int'(a0), 0);

        // R7: Stop after the location byte aborts
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a0);
        send_byte(8'h55, a1);
        bus_stop(); wait_n(8);
        chk(stb_cnt == s0 && !busy, "R7 Stop abort", stb_cnt - s0, 0);

        // R7: repeated Start restarts matching, later write uses new bytes
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a0);
        send_byte(8'h77, a1);
        bus_start();
        send_byte({4'b1010, STRAP, 1'b0}, a0);
        chk(a0, "R7 select ack after repeated Start", int'(a0), 1);
        send_byte(8'h09, a1);
        send_byte(8'hF0, a2);
        bus_stop(); wait_n(4);
        chk(stb_cnt == s0 + 1 && last_addr == 8'h09 && last_data == 8'hF0,
            "R7 write after restart", int'({last_addr, last_data}), 'h09F0);
        wait_idle();

        // Random mix of matching, mismatching and truncated transfers
        for (int it = 0; it < 40; it++) begin
            logic [7:0] sel, loc, val;
            int kind;
            bit want, full;
            kind = int'($urandom % 4);
            sel  = (kind == 1) ? 8'($urandom) : {4'b1010, STRAP, 1'b0};
            loc  = 8'($urandom);
            val  = 8'($urandom);
            full = (kind != 2);
            want = sel_ok(sel);
            s0 = stb_cnt;
            bus_start();
            send_byte(sel, a0);
            chk(a0 == want, "R2 random select ack", int'(a0), int'(want));
            send_byte(loc, a1);
            chk(a1 == want, "R4 random location ack", int'(a1), int'(want));
            if (full) begin
                send_byte(val, a2);
                chk(a2 == want, "R5 random value ack", int'(a2), int'(want));
            end
            bus_stop(); wait_n(4);
            if (want && full) begin
                chk(stb_cnt == s0 + 1 && last_addr == loc && last_data == val,
                    "R6 random write", int'({last_addr, last_data}), int'({loc, val}));
            end else begin
                chk(stb_cnt == s0, "R7 random no write", stb_cnt - s0, 0);
            end
            wait_idle();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule